// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block tracks which clock-gating power state a processor core is in and drives the internal clock enable to match. It has five states: Normal (running), Stop-Grant (clocks stopped after a stop-clock request), AutoHALT (clocks stopped after a halt instruction), Snoop (a short window in which clocks run again to answer a bus snoop or take an interrupt), and Sleep (deepest state, entered from Stop-Grant only, in which nothing is answered).

Events that arrive while the core cannot act on them are held instead of lost. These events are SMI, INIT, the local interrupt lines and bus-delivered interrupts. Each held event produces a single one-cycle service pulse once the core is back in Normal, however many times it arrived. In Stop-Grant, a break-pending output tells system logic that held work exists, so that it can withdraw the stop-clock request. This output does not depend on the interrupt-enable flag.

A snoop or interrupt taken from Stop-Grant or AutoHALT remembers its origin and returns there. A snoop stays until its done strobe arrives. An interrupt returns after one cycle.

Top module: `pwr_state_seq`

## Requirements
- R1: `state_oh` is one-hot with bit 0 Normal, bit 1 Stop-Grant, bit 2 AutoHALT, bit 3 Snoop, bit 4 Sleep. Reset taken in any state other than Stop-Grant, or with `stop_req_n` high, gives Normal after the edge, and all held events are cleared.
- R2: In Normal, `stop_req_n` low moves to Stop-Grant at the next edge. In Stop-Grant, `stop_req_n` high (with no sleep request, snoop or bus interrupt in that cycle) moves to Normal at the next edge.
- R3: In Stop-Grant or AutoHALT, `snoop_start` or a bus interrupt that does not wake the core moves to Snoop. A snoop-entered Snoop waits for `snoop_done` and then returns to its origin at the next edge. An interrupt-entered Snoop returns after one cycle. `snoop_start` in Normal has no effect.
- R4: `sleep_req` high in Stop-Grant moves to Sleep, and `sleep_req` low in Sleep moves back to Stop-Grant. `sleep_req` in Normal has no effect.
- R5: Events are indexed with `svc_pulse` bit 0 SMI, bit 1 INIT, bits 2 and 3 local lines 0 and 1, and bit 4 bus interrupt. An event seen outside Sleep is held. In Normal, every held event drives its `svc_pulse` bit for exactly one cycle and is then cleared, even if it arrived several times.
- R6: `break_pending` is high in Stop-Grant whenever any event is held, whatever `irq_enable` is. It is low in every other state.
- R7: `clk_en` is high in Normal and Snoop, and low in Stop-Grant, AutoHALT and Sleep.
- R8: In Sleep, event inputs and `snoop_start` are ignored: nothing is held and the state does not change.
- R9: Reset in Stop-Grant with `stop_req_n` low clears the held events, and the state stays Stop-Grant until `stop_req_n` goes high.
- R10: Reset taken in Sleep gives Normal at the next edge, without passing through Stop-Grant.
- R11: `halt_hint` in Normal (no stop request) enters AutoHALT. AutoHALT exits to Normal on SMI, on INIT, or on a new or held interrupt while `irq_enable` is high. A masked interrupt does not wake it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_n | input | 1 | Stop-clock request, active low |
| sleep_req | input | 1 | Sleep request, active high |
| halt_hint | input | 1 | Halt instruction retired (enter AutoHALT) |
| snoop_start | input | 1 | Bus snoop begins |
| snoop_done | input | 1 | Bus snoop serviced |
| ev_smi | input | 1 | SMI event |
| ev_init | input | 1 | INIT event |
| ev_lint | input | 2 | Local interrupt lines |
| ev_bus_irq | input | 1 | Interrupt delivered over the bus |
| irq_enable | input | 1 | Interrupt-enable flag, used for AutoHALT wake only |
| state_oh | output | 5 | One-hot current state |
| clk_en | output | 1 | Internal clock enable |
| break_pending | output | 1 | Held events exist while in Stop-Grant |
| svc_pulse | output | 5 | One-cycle service pulses for held events |

## Verification
Every output is decoded from registers only, so the effect of an input pattern shows up after exactly one clock edge. This holds for state changes, clock-enable changes, break-pending changes and service pulses alike. For example, an event seen in Normal is held at that edge, and its pulse is visible straight after it. The bench changes inputs 1 ns after a rising edge and compares all outputs 1 ns after the next rising edge, row by row through a vector table. Multi-cycle cases, such as a long snoop or a reset held in Stop-Grant, are stepped one edge at a time and checked at every step.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int LINT_N   = 2;
    localparam int EV_N     = LINT_N + 3;
    localparam int EV_SMI   = 0;
    localparam int EV_INIT  = 1;
    localparam int EV_LINT0 = 2;
    localparam int EV_BUS   = EV_N - 1;
    localparam int ST_W     = 5;

    typedef enum logic [ST_W-1:0] {
        PS_RUN   = 5'b00001,
        PS_GRANT = 5'b00010,
        PS_HALT  = 5'b00100,
        PS_SNOOP = 5'b01000,
        PS_SLEEP = 5'b10000
    } pstate_e;

    typedef logic [EV_N-1:0] ev_vec_t;

    typedef struct packed {
        pstate_e origin;
        logic    wait_done;
    } snoop_ctx_t;

    function automatic logic clocks_on(pstate_e s);
        return (s == PS_RUN) || (s == PS_SNOOP);
    endfunction

    function automatic logic may_hold(pstate_e s);
        return s != PS_SLEEP;
    endfunction

    function automatic ev_vec_t wake_mask(logic ien);
        ev_vec_t m;
        for (int i = 0; i < EV_N; i++) begin
            m[i] = (i == EV_SMI || i == EV_INIT) ? 1'b1 : ien;
        end
        return m;
    endfunction

endpackage

// File: rtl/pwr_evt_hold.sv
module pwr_evt_hold
    import pwr_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pstate_e st,
    input  ev_vec_t ev_in,
    input  logic    irq_enable,
    output ev_vec_t held,
    output ev_vec_t fire,
    output logic    wake
);

    logic grab;
    logic in_run;

    assign grab   = may_hold(st);
    assign in_run = (st == PS_RUN);
    assign fire   = held & {EV_N{in_run}};
    assign wake   = |((ev_in | held) & wake_mask(irq_enable));

    for (genvar i = 0; i < EV_N; i++) begin : g_hold
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else begin
                bit_q <= (bit_q & ~fire[i]) | (ev_in[i] & grab);
            end
        end
        assign held[i] = bit_q;
    end

endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
    import pwr_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    stop_req_n,
    input  logic    sleep_req,
    input  logic    halt_hint,
    input  logic    snoop_start,
    input  logic    snoop_done,
    input  logic    bus_irq,
    input  logic    wake,
    output pstate_e st_q
);

    pstate_e    st_d;
    snoop_ctx_t ctx_q, ctx_d;
    logic       bus_evt;

    assign bus_evt = snoop_start | bus_irq;

    always_comb begin
        st_d  = st_q;
        ctx_d = ctx_q;
        if (rst) begin
            if (st_q == PS_GRANT && !stop_req_n) begin
                st_d = PS_GRANT;
            end else begin
                st_d = PS_RUN;
            end
            ctx_d.origin    = PS_GRANT;
            ctx_d.wait_done = 1'b0;
        end else begin
            unique case (st_q)
                PS_RUN: begin
                    if (!stop_req_n) begin
                        st_d = PS_GRANT;
                    end else if (halt_hint) begin
                        st_d = PS_HALT;
                    end
                end
                PS_GRANT: begin
                    if (sleep_req) begin
                        st_d = PS_SLEEP;
                    end else if (bus_evt) begin
                        st_d            = PS_SNOOP;
                        ctx_d.origin    = PS_GRANT;
                        ctx_d.wait_done = snoop_start;
                    end else if (stop_req_n) begin
                        st_d = PS_RUN;
                    end
                end
                PS_HALT: begin
                    if (wake) begin
                        st_d = PS_RUN;
                    end else if (bus_evt) begin
                        st_d            = PS_SNOOP;
                        ctx_d.origin    = PS_HALT;
                        ctx_d.wait_done = snoop_start;
                    end
                end
                PS_SNOOP: begin
                    if (!ctx_q.wait_done || snoop_done) begin
                        st_d            = ctx_q.origin;
                        ctx_d.wait_done = 1'b0;
                    end
                end
                PS_SLEEP: begin
                    if (!sleep_req) begin
                        st_d = PS_GRANT;
                    end
                end
                default: st_d = PS_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q  <= st_d;
        ctx_q <= ctx_d;
    end

endmodule

// File: rtl/pwr_seq_outdec.sv
module pwr_seq_outdec
    import pwr_seq_pkg::*;
(
    input  pstate_e         st,
    input  ev_vec_t         held,
    output logic [ST_W-1:0] state_oh,
    output logic            clk_en,
    output logic            break_pending
);

    assign state_oh      = st;
    assign clk_en        = clocks_on(st);
    assign break_pending = (st == PS_GRANT) && (|held);

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
    import pwr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_req_n,
    input  logic              sleep_req,
    input  logic              halt_hint,
    input  logic              snoop_start,
    input  logic              snoop_done,
    input  logic              ev_smi,
    input  logic              ev_init,
    input  logic [LINT_N-1:0] ev_lint,
    input  logic              ev_bus_irq,
    input  logic              irq_enable,
    output logic [ST_W-1:0]   state_oh,
    output logic              clk_en,
    output logic              break_pending,
    output logic [EV_N-1:0]   svc_pulse
);

    pstate_e st;
    ev_vec_t ev_in;
    ev_vec_t held;
    ev_vec_t fire;
    logic    wake;

    assign ev_in     = {ev_bus_irq, ev_lint, ev_init, ev_smi};
    assign svc_pulse = fire;

    pwr_state_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .stop_req_n (stop_req_n),
        .sleep_req  (sleep_req),
        .halt_hint  (halt_hint),
        .snoop_start(snoop_start),
        .snoop_done (snoop_done),
        .bus_irq    (ev_bus_irq),
        .wake       (wake),
        .st_q       (st)
    );

    pwr_evt_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .ev_in     (ev_in),
        .irq_enable(irq_enable),
        .held      (held),
        .fire      (fire),
        .wake      (wake)
    );

    pwr_seq_outdec u_dec (
        .st           (st),
        .held         (held),
        .state_oh     (state_oh),
        .clk_en       (clk_en),
        .break_pending(break_pending)
    );

endmodule

// File: rtl/pwr_state_seq_chk.sv
module pwr_state_seq_chk
    import pwr_seq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [ST_W-1:0] state_oh,
    input logic            clk_en,
    input logic            break_pending,
    input logic [EV_N-1:0] svc_pulse
);

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(state_oh) == 1); // R1

    AST_GRANT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        ($rose(state_oh[1]) && !$past(rst)) |->
            ($past(state_oh[0]) || $past(state_oh[3]) || $past(state_oh[4]))); // R2

    AST_SNOOP_RETURN: assert property (@(posedge clk) disable iff (rst)
        ($fell(state_oh[3]) && !$past(rst)) |-> (state_oh[1] || state_oh[2])); // R3

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        ($rose(state_oh[4]) && !$past(rst)) |-> $past(state_oh[1])); // R4

    AST_PULSE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        (|svc_pulse) |-> state_oh[0]); // R5

    AST_BREAK_IN_GRANT: assert property (@(posedge clk) disable iff (rst)
        break_pending |-> state_oh[1]); // R6

    AST_CLKEN_MATCH: assert property (@(posedge clk) disable iff (rst)
        clk_en == (state_oh[0] || state_oh[3])); // R7

    AST_SLEEP_RESET: assert property (@(posedge clk)
        (rst && state_oh[4]) |=> state_oh[0]); // R10

endmodule

bind pwr_state_seq pwr_state_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .state_oh     (state_oh),
    .clk_en       (clk_en),
    .break_pending(break_pending),
    .svc_pulse    (svc_pulse)
);

// File: tb/pwr_state_seq_tb.sv
module pwr_state_seq_tb;
    import pwr_seq_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst, stop_req_n, sleep_req, halt_hint;
    logic            snoop_start, snoop_done, ev_smi, ev_init, ev_bus_irq, irq_enable;
    logic [1:0]      ev_lint;
    logic [4:0]      state_oh, svc_pulse;
    logic            clk_en, break_pending;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    pwr_state_seq u_dut (
        .clk(clk), .rst(rst), .stop_req_n(stop_req_n), .sleep_req(sleep_req),
        .halt_hint(halt_hint), .snoop_start(snoop_start), .snoop_done(snoop_done),
        .ev_smi(ev_smi), .ev_init(ev_init), .ev_lint(ev_lint), .ev_bus_irq(ev_bus_irq),
        .irq_enable(irq_enable), .state_oh(state_oh), .clk_en(clk_en),
        .break_pending(break_pending), .svc_pulse(svc_pulse)
    );

    // row: {req, ctl = rst,stop_n,sleep,halt,snp_start,snp_done,ien, ev, state, clk_en, brk, svc}
    localparam int NV = 42;
    localparam logic [27:0] VEC [NV] = '{
        {4'd1,  7'b1100000, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b00000}, // R1 reset
        {4'd1,  7'b0100000, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b00000}, // R1
        {4'd2,  7'b0000000, 5'b00000, 5'b00010, 1'b0, 1'b0, 5'b00000}, // R2 enter grant
        {4'd6,  7'b0000000, 5'b00001, 5'b00010, 1'b0, 1'b1, 5'b00000}, // R6 SMI held
        {4'd5,  7'b0000000, 5'b00101, 5'b00010, 1'b0, 1'b1, 5'b00000}, // R5 repeat SMI + lint0, ien=0
        {4'd5,  7'b0100000, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b00101}, // R5 one pulse each
        {4'd5,  7'b0100000, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b00000}, // R5 no second pulse
        {4'd2,  7'b0000000, 5'b00000, 5'b00010, 1'b0, 1'b0, 5'b00000}, // R2
        {4'd3,  7'b0000100, 5'b00000, 5'b01000, 1'b1, 1'b0, 5'b00000}, // R3 snoop
        {4'd3,  7'b0000000, 5'b00000, 5'b01000, 1'b1, 1'b0, 5'b00000}, // R3 waits
        {4'd3,  7'b0000010, 5'b00000, 5'b00010, 1'b0, 1'b0, 5'b00000}, // R3 back to grant
        {4'd3,  7'b0000000, 5'b10000, 5'b01000, 1'b1, 1'b0, 5'b00000}, // R3 bus irq
        {4'd6,  7'b0000000, 5'b00000, 5'b00010, 1'b0, 1'b1, 5'b00000}, // R6 back, held
        {4'd4,  7'b0010000, 5'b00000, 5'b10000, 1'b0, 1'b0, 5'b00000}, // R4 sleep
        {4'd8,  7'b0010100, 5'b00010, 5'b10000, 1'b0, 1'b0, 5'b00000}, // R8 ignored
        {4'd4,  7'b0000000, 5'b00000, 5'b00010, 1'b0, 1'b1, 5'b00000}, // R4 wake to grant
        {4'd8,  7'b0100000, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b10000}, // R8 INIT not held
        {4'd5,  7'b0100000, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b00000}, // R5
        {4'd11, 7'b0101000, 5'b00000, 5'b00100, 1'b0, 1'b0, 5'b00000}, // R11 halt
        {4'd11, 7'b0100000, 5'b01000, 5'b00100, 1'b0, 1'b0, 5'b00000}, // R11 masked lint1
        {4'd11, 7'b0100001, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b01000}, // R11 held wake
        {4'd5,  7'b0100001, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b00000}, // R5
        {4'd11, 7'b0101000, 5'b00000, 5'b00100, 1'b0, 1'b0, 5'b00000}, // R11 halt
        {4'd3,  7'b0100000, 5'b10000, 5'b01000, 1'b1, 1'b0, 5'b00000}, // R3 masked bus irq
        {4'd3,  7'b0100000, 5'b00000, 5'b00100, 1'b0, 1'b0, 5'b00000}, // R3 back to halt
        {4'd11, 7'b0100000, 5'b00001, 5'b00001, 1'b1, 1'b0, 5'b10001}, // R11 SMI wakes
        {4'd5,  7'b0100000, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b00000}, // R5
        {4'd4,  7'b0110000, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b00000}, // R4 ignored in run
        {4'd4,  7'b0100000, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b00000}, // R4
        {4'd9,  7'b0000000, 5'b00000, 5'b00010, 1'b0, 1'b0, 5'b00000}, // R9
        {4'd9,  7'b0000000, 5'b00100, 5'b00010, 1'b0, 1'b1, 5'b00000}, // R9 lint0 held
        {4'd9,  7'b1000000, 5'b00000, 5'b00010, 1'b0, 1'b0, 5'b00000}, // R9 reset stays
        {4'd9,  7'b0000000, 5'b00000, 5'b00010, 1'b0, 1'b0, 5'b00000}, // R9
        {4'd9,  7'b0100000, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b00000}, // R9 nothing to serve
        {4'd10, 7'b0000000, 5'b00000, 5'b00010, 1'b0, 1'b0, 5'b00000}, // R10
        {4'd10, 7'b0010000, 5'b00000, 5'b10000, 1'b0, 1'b0, 5'b00000}, // R10 sleep
        {4'd10, 7'b1010000, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b00000}, // R10 reset to run
        {4'd2,  7'b0000000, 5'b00000, 5'b00010, 1'b0, 1'b0, 5'b00000}, // R2
        {4'd2,  7'b0100000, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b00000}, // R2 leave grant
        {4'd5,  7'b0100000, 5'b00010, 5'b00001, 1'b1, 1'b0, 5'b00010}, // R5 event in run
        {4'd5,  7'b0100000, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b00000}, // R5
        {4'd3,  7'b0100100, 5'b00000, 5'b00001, 1'b1, 1'b0, 5'b00000}  // R3 ignored in run
    };

    task automatic drive(input logic [6:0] ctl, input logic [4:0] ev);
        {rst, stop_req_n, sleep_req, halt_hint, snoop_start, snoop_done, irq_enable} = ctl;
        {ev_bus_irq, ev_lint, ev_init, ev_smi} = ev;
    endtask

    task automatic step_check(input string req, input logic [11:0] exp);
        logic [11:0] got;
        @(posedge clk);
        #1;
        got = {state_oh, clk_en, break_pending, svc_pulse};
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got state=%b ce=%b brk=%b svc=%b, exp state=%b ce=%b brk=%b svc=%b",
                     req, got[11:7], got[6], got[5], got[4:0],
                     exp[11:7], exp[6], exp[5], exp[4:0]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: got timeout, exp completion");
        finish_run();
    end

    initial begin
        drive(7'b1100000, 5'b0);
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][23:17], VEC[i][16:12]);
            step_check($sformatf("R%0d row %0d", VEC[i][27:24], i), VEC[i][11:0]);
        end

        // R3 long snoop from AutoHALT, clocks on throughout
        drive(7'b0101000, 5'b0);
        step_check("R11 halt", {5'b00100, 1'b0, 1'b0, 5'b0});
        drive(7'b0100100, 5'b0);
        step_check("R3 snoop start", {5'b01000, 1'b1, 1'b0, 5'b0});
        drive(7'b0100000, 5'b0);
        for (int k = 0; k < 4; k++) begin
            step_check("R3 snoop held", {5'b01000, 1'b1, 1'b0, 5'b0});
        end
        drive(7'b0100010, 5'b0);
        step_check("R3 return halt", {5'b00100, 1'b0, 1'b0, 5'b0});
        drive(7'b0100000, 5'b00010);
        step_check("R11 INIT wakes", {5'b00001, 1'b1, 1'b0, 5'b00010});

        // R9 reset held in grant, released stop during reset gives run
        drive(7'b0000000, 5'b0);
        step_check("R9 grant", {5'b00010, 1'b0, 1'b0, 5'b0});
        drive(7'b1000000, 5'b01000);
        step_check("R9 reset holds grant", {5'b00010, 1'b0, 1'b0, 5'b0});
        drive(7'b1100000, 5'b0);
        step_check("R1 reset with stop off", {5'b00001, 1'b1, 1'b0, 5'b0});
        drive(7'b0100000, 5'b0);
        step_check("R1 latches clear", {5'b00001, 1'b1, 1'b0, 5'b0});

        finish_run();
    end

endmodule